// File: doc/BRIEF.md
# Multi-Mode Byte Transfer Channel

This block is one channel of a byte mover that copies data between a 24-bit memory-side address and a peripheral-side register window. The peripheral-side address is always in page 0x0021xx. Its low byte is the configured port number plus a small offset. That offset follows a repeating per-byte pattern that the transfer mode selects, so multi-register peripherals can be fed in interleaved order. The channel drives a simple bus master: one read strobe, one write strobe, one address, and write and read data buses.

Software loads the direction, the mode, the address-step controls, the port number, the memory-side address and a 16-bit byte count. A single start pulse then hands the job to the channel. Each byte is charged a number of bus cycles. The channel stops when the count is used up or when the charged total reaches a budget given at start. It then raises a one-clock done pulse and holds the total, the final address and the remaining count on its outputs.

One port number, 0x80, is special. When it is used and the memory-side address falls in work RAM, no normal copy takes place. In the memory-to-peripheral direction no access is made at all. In the peripheral-to-memory direction the value 0xFF is stored to memory instead.

Top module: `bytemover_chan`

## Requirements
- R1: After a synchronous reset, busy and done are 0, no bus strobe is active, and cycles_total is 0.
- R2: The peripheral-side address is {16'h0021, port + off}, taken modulo 256. The offset off for the byte with index i (counted from 0) is set by cfg_mode. Code 0 gives 0. Code 1 gives i mod 2. Code 2 gives 0. Code 3 gives 1 when (i & 3) > 1, and 0 otherwise. Code 4 gives i & 3.
- R3: Each byte takes two clocks. When cfg_dir is 0 (memory to peripheral), the first clock reads the memory address and the second clock writes the read byte to the peripheral address. When cfg_dir is 1, the read is from the peripheral address and the write goes to the memory address. bus_rd and bus_wr are never high together.
- R4: After each byte, the low 16 bits of the memory address step by 1. The step is a decrement when cfg_down is 1 and an increment otherwise. The step wraps within the bank, and no step happens when cfg_fixed is 1. Bits 23:16 never change.
- R5: The remaining count drops by 1 per byte. At least one byte always moves, and the transfer continues while the count is nonzero, so a loaded count of 0 behaves as 65536.
- R6: cycles_total starts at 8 and grows by 8 for each normal byte. The transfer ends after the first byte that brings the total to a value greater than or equal to max_cycles.
- R7: When the port is 0x80, cfg_dir is 0 and the memory address is in work RAM, neither strobe is raised for that byte, and 8 cycles are charged.
- R8: When the port is 0x80, cfg_dir is 1 and the memory address is in work RAM, the first clock writes 0xFF to the memory address, the second clock makes no access, and 4 cycles are charged.
- R9: Work RAM means banks 0x7E and 0x7F in full, plus offsets 0x0000 to 0x1FFF in banks 0x00 to 0x3F and 0x80 to 0xBF.
- R10: A start pulse that arrives while busy is 1 has no effect on the running transfer.
- R11: done is high for exactly one clock after the last byte. At that time busy is 0, and cur_addr, remain and cycles_total show the final address, the remaining count and the charged total.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-clock request to begin a transfer |
| cfg_dir | input | 1 | 0: memory to peripheral, 1: peripheral to memory |
| cfg_mode | input | 3 | Offset pattern code (see R2) |
| cfg_fixed | input | 1 | Keep the memory address constant |
| cfg_down | input | 1 | Step the memory address downward |
| cfg_port | input | 8 | Peripheral register number |
| cfg_addr | input | 24 | Initial memory-side address |
| cfg_count | input | 16 | Byte count (0 means 65536) |
| max_cycles | input | 32 | Cycle budget for this transfer |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_addr | output | 24 | Bus address |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, valid in the same clock as bus_rd |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-clock completion pulse |
| cycles_total | output | 32 | Charged cycle total |
| cur_addr | output | 24 | Current memory-side address |
| remain | output | 16 | Remaining byte count |

## Verification
The hardest case to reach is the work-RAM rule switching on or off in the middle of a transfer. Reaching it needs port 0x80 and an address that crosses the edge of the low work-RAM window. The stimulus therefore starts a peripheral-to-memory job just below offset 0x2000 in bank 0x00. This makes the first bytes fill with 0xFF at 4 cycles each, and the later bytes then turn into normal copies. A second hard case is a loaded count of zero. It is cut short by a small cycle budget, so the run shows that the count wrapped and kept going without moving all 65536 bytes.

// File: rtl/bm_pkg.sv
package bm_pkg;
  typedef enum logic [2:0] {
    MODE_SINGLE = 3'd0,
    MODE_PAIR   = 3'd1,
    MODE_DUP    = 3'd2,
    MODE_PAIR2  = 3'd3,
    MODE_QUAD   = 3'd4
  } xfer_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2
  } chan_st_e;
endpackage

// File: rtl/bm_port_offset.sv
module bm_port_offset
  import bm_pkg::*;
#(
  parameter int OFF_W = 2
) (
  input  logic [2:0]       mode,
  input  logic [OFF_W-1:0] idx,
  output logic [OFF_W-1:0] off
);
  always_comb begin
    off = '0;
    case (xfer_mode_e'(mode))
      MODE_PAIR:  off = {{(OFF_W-1){1'b0}}, idx[0]};
      MODE_PAIR2: off = {{(OFF_W-1){1'b0}}, idx[1]};
      MODE_QUAD:  off = idx;
      default:    off = '0;
    endcase
  end
endmodule

// File: rtl/bm_wram_hit.sv
module bm_wram_hit #(
  parameter int A_W = 24
) (
  input  logic [A_W-1:0] addr,
  output logic           hit
);
  localparam int BANK_LSB = A_W - 8;
  logic [7:0]  bank;
  logic [15:0] ofs;
  logic        full_bank;
  logic        low_mirror;

  assign bank       = addr[A_W-1:BANK_LSB];
  assign ofs        = addr[15:0];
  assign full_bank  = (bank[7:1] == 7'h3F);
  assign low_mirror = (bank[6] == 1'b0) && (ofs[15:13] == 3'b000);
  assign hit        = full_bank || low_mirror;
endmodule

// File: rtl/bytemover_chan.sv
module bytemover_chan
  import bm_pkg::*;
#(
  parameter int          A_W        = 24,
  parameter int          CNT_W      = 16,
  parameter int          CYC_W      = 32,
  parameter int          D_W        = 8,
  parameter logic [15:0] B_PAGE     = 16'h0021,
  parameter logic [7:0]  WRAM_PORT  = 8'h80,
  parameter int          SETUP_CYC  = 8,
  parameter int          BYTE_CYC   = 8,
  parameter int          FILL_CYC   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             cfg_dir,
  input  logic [2:0]       cfg_mode,
  input  logic             cfg_fixed,
  input  logic             cfg_down,
  input  logic [7:0]       cfg_port,
  input  logic [A_W-1:0]   cfg_addr,
  input  logic [CNT_W-1:0] cfg_count,
  input  logic [CYC_W-1:0] max_cycles,
  output logic             bus_rd,
  output logic             bus_wr,
  output logic [A_W-1:0]   bus_addr,
  output logic [D_W-1:0]   bus_wdata,
  input  logic [D_W-1:0]   bus_rdata,
  output logic             busy,
  output logic             done,
  output logic [CYC_W-1:0] cycles_total,
  output logic [A_W-1:0]   cur_addr,
  output logic [CNT_W-1:0] remain
);
  localparam int OFF_W = 2;
  localparam logic [CYC_W-1:0] SETUP_V = CYC_W'(SETUP_CYC);
  localparam logic [CYC_W-1:0] BYTE_V  = CYC_W'(BYTE_CYC);
  localparam logic [CYC_W-1:0] FILL_V  = CYC_W'(FILL_CYC);

  chan_st_e         st;
  logic             dir_q, fixed_q, down_q;
  logic [2:0]       mode_q;
  logic [7:0]       port_q;
  logic [A_W-1:0]   addr_q;
  logic [CNT_W-1:0] cnt_q;
  logic [OFF_W-1:0] idx_q;
  logic [CYC_W-1:0] cyc_q, max_q;
  logic [D_W-1:0]   data_q;
  logic             done_q;

  logic [OFF_W-1:0] off;
  logic             wram;
  logic             special;
  logic [A_W-1:0]   b_addr;
  logic [CYC_W-1:0] charge, cyc_nx;
  logic [CNT_W-1:0] cnt_nx;
  logic [15:0]      ofs_nx;

  bm_port_offset #(.OFF_W(OFF_W)) u_off (
    .mode (mode_q),
    .idx  (idx_q),
    .off  (off)
  );

  bm_wram_hit #(.A_W(A_W)) u_wram (
    .addr (addr_q),
    .hit  (wram)
  );

  assign special = (port_q == WRAM_PORT) && wram;
  assign b_addr  = {B_PAGE, port_q + {{(8-OFF_W){1'b0}}, off}};

  always_comb begin
    bus_rd    = 1'b0;
    bus_wr    = 1'b0;
    bus_addr  = '0;
    bus_wdata = '0;
    if (st == ST_RD) begin
      if (special) begin
        if (dir_q) begin
          bus_wr    = 1'b1;
          bus_addr  = addr_q;
          bus_wdata = {D_W{1'b1}};
        end
      end else begin
        bus_rd   = 1'b1;
        bus_addr = dir_q ? b_addr : addr_q;
      end
    end else if (st == ST_WR && !special) begin
      bus_wr    = 1'b1;
      bus_addr  = dir_q ? addr_q : b_addr;
      bus_wdata = data_q;
    end
  end

  always_comb begin
    charge = (special && dir_q) ? FILL_V : BYTE_V;
    cyc_nx = cyc_q + charge;
    cnt_nx = cnt_q - 1'b1;
    if (fixed_q)     ofs_nx = addr_q[15:0];
    else if (down_q) ofs_nx = addr_q[15:0] - 16'd1;
    else             ofs_nx = addr_q[15:0] + 16'd1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      dir_q   <= 1'b0;
      fixed_q <= 1'b0;
      down_q  <= 1'b0;
      mode_q  <= '0;
      port_q  <= '0;
      addr_q  <= '0;
      cnt_q   <= '0;
      idx_q   <= '0;
      cyc_q   <= '0;
      max_q   <= '0;
      data_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start) begin
            st      <= ST_RD;
            dir_q   <= cfg_dir;
            fixed_q <= cfg_fixed;
            down_q  <= cfg_down;
            mode_q  <= cfg_mode;
            port_q  <= cfg_port;
            addr_q  <= cfg_addr;
            cnt_q   <= cfg_count;
            max_q   <= max_cycles;
            idx_q   <= '0;
            cyc_q   <= SETUP_V;
          end
        end
        ST_RD: begin
          data_q <= bus_rdata;
          st     <= ST_WR;
        end
        ST_WR: begin
          addr_q <= {addr_q[A_W-1:16], ofs_nx};
          cnt_q  <= cnt_nx;
          cyc_q  <= cyc_nx;
          idx_q  <= idx_q + 1'b1;
          if (cnt_nx != '0 && cyc_nx < max_q) begin
            st <= ST_RD;
          end else begin
            st     <= ST_IDLE;
            done_q <= 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy         = (st != ST_IDLE);
  assign done         = done_q;
  assign cycles_total = cyc_q;
  assign cur_addr     = addr_q;
  assign remain       = cnt_q;

  a_r3_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(bus_rd && bus_wr));

  a_r11_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r10_start_ignored: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> ($stable(port_q) && $stable(mode_q) && $stable(dir_q)));

  a_r4_bank_kept: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WR) |=> (addr_q[A_W-1:16] == $past(addr_q[A_W-1:16])));

  a_r6_total_grows: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WR) |=> (cyc_q > $past(cyc_q)));

  a_r7_no_access_fill_skip: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RD && special && !dir_q) |-> (!bus_rd && !bus_wr));
endmodule

// File: tb/test_bytemover_chan.sv
module test_bytemover_chan;
  logic        clk = 1'b0;
  logic        rst;
  logic        start;
  logic        cfg_dir, cfg_fixed, cfg_down;
  logic [2:0]  cfg_mode;
  logic [7:0]  cfg_port;
  logic [23:0] cfg_addr;
  logic [15:0] cfg_count;
  logic [31:0] max_cycles;
  logic        bus_rd, bus_wr;
  logic [23:0] bus_addr;
  logic [7:0]  bus_wdata, bus_rdata;
  logic        busy, done;
  logic [31:0] cycles_total;
  logic [23:0] cur_addr;
  logic [15:0] remain;

  int checks = 0;
  int errors = 0;
  int ticks  = 0;

  bit          q_rd[$];
  bit          q_wr[$];
  logic [23:0] q_a[$];
  logic [7:0]  q_d[$];
  string       q_tag[$];

  always #2.5 clk = ~clk;

  bytemover_chan i_bytemover_chan (
    .clk(clk), .rst(rst), .start(start), .cfg_dir(cfg_dir), .cfg_mode(cfg_mode),
    .cfg_fixed(cfg_fixed), .cfg_down(cfg_down), .cfg_port(cfg_port),
    .cfg_addr(cfg_addr), .cfg_count(cfg_count), .max_cycles(max_cycles),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .busy(busy), .done(done), .cycles_total(cycles_total),
    .cur_addr(cur_addr), .remain(remain)
  );

  function automatic logic [7:0] pat(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
  endfunction

  assign bus_rdata = bus_rd ? pat(bus_addr) : 8'h00;

  function automatic bit is_wram(input logic [23:0] a);
    int bank = int'(a[23:16]);
    int ofs  = int'(a[15:0]);
    if (bank == 'h7E || bank == 'h7F) return 1'b1;
    if ((bank <= 'h3F || (bank >= 'h80 && bank <= 'hBF)) && ofs < 'h2000) return 1'b1;
    return 1'b0;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic push(input bit rd, input bit wr, input logic [23:0] a,
                      input logic [7:0] d, input string tag);
    q_rd.push_back(rd); q_wr.push_back(wr); q_a.push_back(a);
    q_d.push_back(d); q_tag.push_back(tag);
  endtask

  task automatic model(input bit dir, input int mode, input bit fixed, input bit down,
                       input logic [7:0] port, input logic [23:0] addr,
                       input logic [15:0] count, input longint mx,
                       output longint e_cyc, output logic [23:0] e_addr,
                       output logic [15:0] e_rem);
    longint cyc = 8;
    int i = 0;
    logic [23:0] a = addr;
    logic [15:0] n = count;
    do begin
      int off;
      logic [23:0] b;
      case (mode)
        1: off = i % 2;
        3: off = ((i & 3) > 1) ? 1 : 0;
        4: off = i & 3;
        default: off = 0;
      endcase
      b = {16'h0021, 8'(int'(port) + off)};
      if (port == 8'h80 && is_wram(a)) begin
        if (dir) begin
          push(1'b0, 1'b1, a, 8'hFF, "R8");
          push(1'b0, 1'b0, 24'h0, 8'h0, "R8");
          cyc += 4;
        end else begin
          push(1'b0, 1'b0, 24'h0, 8'h0, "R7");
          push(1'b0, 1'b0, 24'h0, 8'h0, "R7");
          cyc += 8;
        end
      end else if (dir) begin
        push(1'b1, 1'b0, b, 8'h0, "R2");
        push(1'b0, 1'b1, a, pat(b), "R3");
        cyc += 8;
      end else begin
        push(1'b1, 1'b0, a, 8'h0, "R4");
        push(1'b0, 1'b1, b, pat(a), "R2");
        cyc += 8;
      end
      if (!fixed) a[15:0] = down ? a[15:0] - 16'd1 : a[15:0] + 16'd1;
      n = n - 16'd1;
      i++;
    end while (n != 0 && cyc < mx);
    e_cyc = cyc; e_addr = a; e_rem = n;
  endtask

  // inj: entry index at which an extra start pulse is driven (-1 for none)
  task automatic run(input string name, input bit dir, input int mode, input bit fixed,
                     input bit down, input logic [7:0] port, input logic [23:0] addr,
                     input logic [15:0] count, input longint mx, input int inj);
    longint e_cyc; logic [23:0] e_addr; logic [15:0] e_rem;
    int n;
    model(dir, mode, fixed, down, port, addr, count, mx, e_cyc, e_addr, e_rem);
    n = q_rd.size();
    cfg_dir = dir; cfg_mode = 3'(mode); cfg_fixed = fixed; cfg_down = down;
    cfg_port = port; cfg_addr = addr; cfg_count = count; max_cycles = 32'(mx);
    start = 1'b1;
    @(negedge clk);
    for (int k = 0; k < n; k++) begin
      string t = q_tag[k];
      chk(busy === 1'b1 && done === 1'b0, "R11", {name, " busy"}, {busy, done}, 2'b10);
      chk(bus_rd === q_rd[k], t, {name, " rd strobe"}, bus_rd, q_rd[k]);
      chk(bus_wr === q_wr[k], t, {name, " wr strobe"}, bus_wr, q_wr[k]);
      if (q_rd[k] || q_wr[k])
        chk(bus_addr === q_a[k], t, {name, " address"}, bus_addr, q_a[k]);
      if (q_wr[k])
        chk(bus_wdata === q_d[k], t, {name, " data"}, bus_wdata, q_d[k]);
      start = (k == inj);
      if (k == inj) begin cfg_port = 8'h33; cfg_mode = 3'd4; cfg_count = 16'd1; end
      @(negedge clk);
    end
    start = 1'b0;
    chk(done === 1'b1 && busy === 1'b0, "R11", {name, " done pulse"}, {done, busy}, 2'b10);
    chk(cycles_total === 32'(e_cyc), "R6", {name, " cycles"}, cycles_total, e_cyc);
    chk(cur_addr === e_addr, "R4", {name, " final addr"}, cur_addr, e_addr);
    chk(remain === e_rem, "R5", {name, " remain"}, remain, e_rem);
    @(negedge clk);
    chk(done === 1'b0, "R11", {name, " done width"}, done, 0);
    q_rd.delete(); q_wr.delete(); q_a.delete(); q_d.delete(); q_tag.delete();
  endtask

  always @(posedge clk) begin
    ticks++;
    if (ticks > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected below 100000", ticks);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; start = 1'b0;
    cfg_dir = 0; cfg_mode = 0; cfg_fixed = 0; cfg_down = 0;
    cfg_port = 0; cfg_addr = 0; cfg_count = 0; max_cycles = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(busy === 0 && done === 0, "R1", "reset busy/done", {busy, done}, 0);
    chk(bus_rd === 0 && bus_wr === 0, "R1", "reset strobes", {bus_rd, bus_wr}, 0);
    chk(cycles_total === 0, "R1", "reset cycles", cycles_total, 0);

    // R2 R3 R4: normal copies, each mode, both directions and step kinds
    run("m0 a2b inc",    0, 0, 0, 0, 8'h18, 24'h00_8000, 16'd3, 1000, -1);
    run("m1 b2a dec",    1, 1, 0, 1, 8'h04, 24'h05_4010, 16'd4, 1000, -1);
    run("m2 a2b fixed",  0, 2, 1, 0, 8'h22, 24'h40_1234, 16'd4, 1000, -1);
    run("m3 b2a inc",    1, 3, 0, 0, 8'h10, 24'hC1_0100, 16'd8, 1000, -1);
    run("m4 a2b dec",    0, 4, 0, 1, 8'h30, 24'h41_0003, 16'd8, 1000, -1);
    // R2: port plus offset wraps within the low byte
    run("m4 port wrap",  1, 4, 0, 0, 8'hFF, 24'h42_0000, 16'd4, 1000, -1);
    // R4: bank kept on up and down wrap
    run("bank wrap up",  0, 0, 0, 0, 8'h01, 24'h12_FFFF, 16'd2, 1000, -1);
    run("bank wrap dn",  1, 0, 0, 1, 8'h01, 24'h12_0000, 16'd2, 1000, -1);
    // R7 R9: fill port, memory-to-peripheral, high work-RAM bank
    run("fill a2b",      0, 0, 0, 0, 8'h80, 24'h7E_0010, 16'd2, 1000, -1);
    // R8 R9: fill port crossing the end of the low window in bank 00
    run("fill b2a edge", 1, 0, 0, 0, 8'h80, 24'h00_1FFE, 16'd4, 1000, -1);
    // R9: fill port outside work RAM (bank 40, bank 7D) behaves normally
    run("fill not wram", 1, 0, 0, 0, 8'h80, 24'h40_0010, 16'd2, 1000, -1);
    run("fill bank7d",   0, 0, 0, 0, 8'h80, 24'h7D_0010, 16'd2, 1000, -1);
    // R5: loaded count 0 wraps and keeps going until the budget
    run("count zero",    0, 1, 0, 0, 8'h18, 24'h01_3000, 16'd0, 40, -1);
    // R6: budget ends the transfer early
    run("budget",        1, 4, 0, 0, 8'h18, 24'h01_3000, 16'd10, 30, -1);
    // R10: extra start while busy is ignored
    run("restart busy",  0, 1, 0, 0, 8'h44, 24'h02_3000, 16'd5, 1000, 3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule